// File: doc/BRIEF.md
# Stream-to-Memory DMA Receive Channel

This block moves an incoming byte stream into memory buffers that are described by a linked list of descriptors. When it is started with a descriptor pointer and a context pointer, it reads the four-word descriptor. It then accepts bytes from a valid/ready stream and places them one after another from the buffer start address. The buffer closes when the write position reaches the buffer's end address, or when a byte arrives marked as the last of a packet, whichever happens first.

On close, the channel rewrites the descriptor's end address with the real fill point and writes the flag word back, marking whether the packet boundary caused the close. If the descriptor asks for it, the channel raises a sticky data interrupt. The channel then either follows the next pointer or, at the end of the list, marks the context word as disabled, raises its end-of-list status and stops.

The memory side is a single word port with byte enables and a fixed one-cycle read latency. A trailing partial word is written with only its own byte lanes enabled.

Top module: `dmarx_channel`

## Requirements
- R1: After reset, `s_ready_o`, `run_o`, `eol_o` and `intr_o` are all low and no memory request is made.
- R2: A descriptor is four consecutive words at the descriptor word pointer: offset 0 is the next-descriptor byte address, offset 1 the buffer start byte address, offset 2 the buffer end byte address (exclusive), and offset 3 the flag word (bit 0 end-of-list, bit 1 interrupt enable, bit 2 closed-by-packet-end). The channel reads all four before it raises `s_ready_o`, and `s_ready_o` is low during every descriptor read or write-back.
- R3: Accepted bytes are stored at consecutive byte addresses from the buffer start, and no byte is ever written at or beyond the buffer end address.
- R4: A buffer closes when it becomes full or when a byte with `s_eop_i` high is accepted, whichever comes first; the next byte goes to the next descriptor's buffer.
- R5: On close, descriptor word 2 is overwritten with the byte address one past the last byte stored.
- R6: On close, descriptor word 3 is written back with bit 2 set if the packet end closed the buffer and cleared otherwise; all other flag bits keep their fetched value.
- R7: On close of a descriptor whose flag bit 1 is set, `intr_o` goes high and stays high until `intr_clr_i` is pulsed. A descriptor with bit 1 clear does not raise it.
- R8: On close of a descriptor with flag bit 0 set, the channel writes 1 (bit 0 = disable) to the context word, sets `eol_o`, drops `run_o`, and accepts no further bytes.
- R9: Without end-of-list, the channel fetches the descriptor at the next pointer and continues from that buffer's start. A descriptor whose start equals its end closes at once, without accepting a byte.
- R10: Memory writes of buffer data carry byte enables for exactly the lanes stored, so the bytes next to a buffer in a shared word are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, taken only while the channel is not running |
| desc_ptr_i | input | ADDR_W-2 | Word pointer to the first descriptor |
| ctx_ptr_i | input | ADDR_W-2 | Word pointer to the context word |
| intr_clr_i | input | 1 | Clears the sticky data interrupt |
| s_valid_i | input | 1 | Stream byte valid |
| s_data_i | input | 8 | Stream byte |
| s_eop_i | input | 1 | Marks the byte as the last of a packet |
| s_ready_o | output | 1 | Channel accepts a byte this cycle |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Write (1) or read (0) |
| mem_addr_o | output | ADDR_W-2 | Word address |
| mem_be_o | output | 4 | Byte enables for writes |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid the cycle after a read request |
| run_o | output | 1 | Channel is active |
| eol_o | output | 1 | End-of-list reached |
| intr_o | output | 1 | Sticky data interrupt |

## Verification
The bench builds the channel with a 12-bit byte address space and the packet-end marking enabled, so that the whole memory can be held and compared word by word. The buffers are placed to start and end mid-word, which exposes the partial first and last words. One chain closes once on a packet end and once on a full buffer followed by end-of-list. A second chain runs a zero-length descriptor into a word-aligned buffer, where fill and packet end coincide. Every memory write is compared on the clock it happens against the final image the reference model predicted.

// File: rtl/dmarx_pkg.sv
package dmarx_pkg;

   localparam int WORD_W      = 32;
   localparam int WORD_BYTES  = WORD_W / 8;
   localparam int DESC_WORDS  = 4;

   // descriptor word offsets
   localparam int OFS_NEXT  = 0;
   localparam int OFS_START = 1;
   localparam int OFS_END   = 2;
   localparam int OFS_FLAGS = 3;

   // flag word bits
   localparam int FL_LAST   = 0;
   localparam int FL_IRQ    = 1;
   localparam int FL_PKTEND = 2;

   // context word disable bit
   localparam int CTX_DIS   = 0;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_RECV,
      ST_WBACK,
      ST_CTX
   } rx_state_e;

endpackage

// File: rtl/dmarx_lane_pack.sv
module dmarx_lane_pack
   import dmarx_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  take_i,
   input  logic [1:0]            lane_i,
   input  logic [7:0]            byte_i,
   input  logic                  close_i,
   output logic                  wr_o,
   output logic [WORD_W-1:0]     wdata_o,
   output logic [WORD_BYTES-1:0] be_o
);

   localparam int LAST_LANE = WORD_BYTES - 1;

   logic [WORD_W-1:0]     acc_q;
   logic [WORD_BYTES-1:0] acc_be_q;
   logic [WORD_W-1:0]     merged;
   logic [WORD_BYTES-1:0] merged_be;

   for (genvar l = 0; l < WORD_BYTES; l++) begin : g_lane
      logic hit;
      assign hit             = take_i && (lane_i == 2'(l));
      assign merged[8*l +: 8] = hit ? byte_i : acc_q[8*l +: 8];
      assign merged_be[l]     = acc_be_q[l] | hit;
   end

   assign wr_o    = take_i && ((lane_i == 2'(LAST_LANE)) || close_i);
   assign wdata_o = merged;
   assign be_o    = merged_be;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q    <= '0;
         acc_be_q <= '0;
      end else if (wr_o) begin
         acc_be_q <= '0;
      end else if (take_i) begin
         acc_q    <= merged;
         acc_be_q <= merged_be;
      end
   end

endmodule

// File: rtl/dmarx_seq.sv
module dmarx_seq
   import dmarx_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter bit MARK_EOP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-3:0] desc_ptr_i,
   input  logic [ADDR_W-3:0] ctx_ptr_i,
   input  logic              intr_clr_i,
   input  logic              s_valid_i,
   input  logic              s_eop_i,
   input  logic [WORD_W-1:0] mem_rdata_i,
   output logic              ready_o,
   output logic              take_o,
   output logic              close_o,
   output logic [ADDR_W-1:0] pos_o,
   output logic              req_o,
   output logic              we_o,
   output logic [ADDR_W-3:0] addr_o,
   output logic [WORD_W-1:0] wdata_o,
   output logic              run_o,
   output logic              eol_o,
   output logic              intr_o
);

   localparam int WA_W  = ADDR_W - 2;
   localparam int CNT_W = 3;

   rx_state_e          state_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [WA_W-1:0]    desc_q, ctx_q, next_q;
   logic [ADDR_W-1:0]  pos_q, end_q;
   logic [WORD_W-1:0]  flags_q;
   logic               by_eop_q, eol_q, intr_q;
   logic [ADDR_W-1:0]  pos_nx;
   logic [WORD_W-1:0]  wb_flags;
   logic               set_intr;
   logic               unused_sink;

   assign unused_sink = ^{mem_rdata_i, by_eop_q};

   if (MARK_EOP) begin : g_mark
      always_comb begin
         wb_flags            = flags_q;
         wb_flags[FL_PKTEND] = by_eop_q;
      end
   end else begin : g_keep
      assign wb_flags = flags_q;
   end

   assign pos_nx  = pos_q + 1'b1;
   assign ready_o = (state_q == ST_RECV);
   assign take_o  = ready_o && s_valid_i;
   assign close_o = take_o && (s_eop_i || (pos_nx == end_q));
   assign pos_o   = pos_q;
   assign run_o   = (state_q != ST_IDLE);
   assign eol_o   = eol_q;
   assign intr_o  = intr_q;
   assign set_intr = (state_q == ST_WBACK) && (cnt_q == '0) && flags_q[FL_IRQ];

   always_comb begin
      req_o   = 1'b0;
      we_o    = 1'b0;
      addr_o  = desc_q;
      wdata_o = '0;
      unique case (state_q)
         ST_FETCH: begin
            req_o  = (cnt_q < CNT_W'(DESC_WORDS));
            addr_o = desc_q + WA_W'(cnt_q);
         end
         ST_WBACK: begin
            req_o  = 1'b1;
            we_o   = 1'b1;
            addr_o = desc_q + WA_W'(OFS_END) + WA_W'(cnt_q);
            wdata_o = (cnt_q == '0) ? WORD_W'(pos_q) : wb_flags;
         end
         ST_CTX: begin
            req_o   = 1'b1;
            we_o    = 1'b1;
            addr_o  = ctx_q;
            wdata_o = WORD_W'(1) << CTX_DIS;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         cnt_q    <= '0;
         desc_q   <= '0;
         ctx_q    <= '0;
         next_q   <= '0;
         pos_q    <= '0;
         end_q    <= '0;
         flags_q  <= '0;
         by_eop_q <= 1'b0;
         eol_q    <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (start_i) begin
               desc_q  <= desc_ptr_i;
               ctx_q   <= ctx_ptr_i;
               eol_q   <= 1'b0;
               cnt_q   <= '0;
               state_q <= ST_FETCH;
            end
            ST_FETCH: begin
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q != '0) begin
                  unique case (int'(cnt_q) - 1)
                     OFS_NEXT:  next_q  <= mem_rdata_i[ADDR_W-1:2];
                     OFS_START: pos_q   <= mem_rdata_i[ADDR_W-1:0];
                     OFS_END:   end_q   <= mem_rdata_i[ADDR_W-1:0];
                     default:   flags_q <= mem_rdata_i;
                  endcase
               end
               if (cnt_q == CNT_W'(DESC_WORDS)) begin
                  cnt_q <= '0;
                  if (pos_q == end_q) begin
                     by_eop_q <= 1'b0;
                     state_q  <= ST_WBACK;
                  end else begin
                     state_q  <= ST_RECV;
                  end
               end
            end
            ST_RECV: if (take_o) begin
               pos_q <= pos_nx;
               if (close_o) begin
                  by_eop_q <= s_eop_i;
                  cnt_q    <= '0;
                  state_q  <= ST_WBACK;
               end
            end
            ST_WBACK: begin
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == CNT_W'(1)) begin
                  cnt_q <= '0;
                  if (flags_q[FL_LAST]) begin
                     state_q <= ST_CTX;
                  end else begin
                     desc_q  <= next_q;
                     state_q <= ST_FETCH;
                  end
               end
            end
            ST_CTX: begin
               eol_q   <= 1'b1;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          intr_q <= 1'b0;
      else if (set_intr)   intr_q <= 1'b1;
      else if (intr_clr_i) intr_q <= 1'b0;
   end

   // R3
   pos_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o |-> (pos_q != end_q));

   // R7
   intr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (intr_q && !intr_clr_i) |=> intr_q);

endmodule

// File: rtl/dmarx_channel.sv
module dmarx_channel
   import dmarx_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter bit MARK_EOP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-3:0] desc_ptr_i,
   input  logic [ADDR_W-3:0] ctx_ptr_i,
   input  logic              intr_clr_i,
   input  logic              s_valid_i,
   input  logic [7:0]        s_data_i,
   input  logic              s_eop_i,
   output logic              s_ready_o,
   output logic              mem_req_o,
   output logic              mem_we_o,
   output logic [ADDR_W-3:0] mem_addr_o,
   output logic [3:0]        mem_be_o,
   output logic [31:0]       mem_wdata_o,
   input  logic [31:0]       mem_rdata_i,
   output logic              run_o,
   output logic              eol_o,
   output logic              intr_o
);

   if (ADDR_W < 8 || ADDR_W > WORD_W) begin : g_bad_addr_w
      $error("dmarx_channel: ADDR_W must lie in 8..32");
   end
   if (WORD_BYTES != 4) begin : g_bad_word
      $error("dmarx_channel: word must hold four bytes");
   end

   logic              take, close, seq_req, seq_we;
   logic [ADDR_W-1:0] pos;
   logic [ADDR_W-3:0] seq_addr;
   logic [31:0]       seq_wdata, pk_wdata;
   logic              pk_wr;
   logic [3:0]        pk_be;

   dmarx_seq #(.ADDR_W(ADDR_W), .MARK_EOP(MARK_EOP)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .desc_ptr_i (desc_ptr_i),
      .ctx_ptr_i  (ctx_ptr_i),
      .intr_clr_i (intr_clr_i),
      .s_valid_i  (s_valid_i),
      .s_eop_i    (s_eop_i),
      .mem_rdata_i(mem_rdata_i),
      .ready_o    (s_ready_o),
      .take_o     (take),
      .close_o    (close),
      .pos_o      (pos),
      .req_o      (seq_req),
      .we_o       (seq_we),
      .addr_o     (seq_addr),
      .wdata_o    (seq_wdata),
      .run_o      (run_o),
      .eol_o      (eol_o),
      .intr_o     (intr_o)
   );

   dmarx_lane_pack u_pack (
      .clk     (clk),
      .rst_n   (rst_n),
      .take_i  (take),
      .lane_i  (pos[1:0]),
      .byte_i  (s_data_i),
      .close_i (close),
      .wr_o    (pk_wr),
      .wdata_o (pk_wdata),
      .be_o    (pk_be)
   );

   assign mem_req_o   = seq_req | pk_wr;
   assign mem_we_o    = pk_wr ? 1'b1 : seq_we;
   assign mem_addr_o  = pk_wr ? pos[ADDR_W-1:2] : seq_addr;
   assign mem_be_o    = pk_wr ? pk_be : 4'hF;
   assign mem_wdata_o = pk_wr ? pk_wdata : seq_wdata;

   // R2
   fetch_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_we_o) |-> !s_ready_o);

   // R2
   ready_after_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(s_ready_o) |-> $past(mem_req_o && !mem_we_o, 2));

   // R8
   eol_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eol_o |-> (!s_ready_o && !run_o));

   // R10
   be_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && mem_we_o) |-> (mem_be_o != 4'h0));

endmodule

// File: tb/test_dmarx_channel.sv
module test_dmarx_channel;

   localparam int AW    = 12;
   localparam int WORDS = 1 << (AW - 2);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic [AW-3:0] desc_ptr_i = '0;
   logic [AW-3:0] ctx_ptr_i = '0;
   logic intr_clr_i = 1'b0;
   logic s_valid_i = 1'b0;
   logic [7:0] s_data_i = '0;
   logic s_eop_i = 1'b0;
   logic s_ready_o, mem_req_o, mem_we_o, run_o, eol_o, intr_o;
   logic [AW-3:0] mem_addr_o;
   logic [3:0] mem_be_o;
   logic [31:0] mem_wdata_o;
   logic [31:0] mem_rdata_i = '0;

   logic [31:0] mem [WORDS];
   logic [31:0] expm [WORDS];
   logic [7:0] sq[$];
   logic       seq_eop[$];
   logic [7:0] mq[$];
   logic       meq[$];

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   dmarx_channel #(.ADDR_W(AW), .MARK_EOP(1'b1)) i_dmarx_channel (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .desc_ptr_i(desc_ptr_i),
      .ctx_ptr_i(ctx_ptr_i), .intr_clr_i(intr_clr_i), .s_valid_i(s_valid_i),
      .s_data_i(s_data_i), .s_eop_i(s_eop_i), .s_ready_o(s_ready_o),
      .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
      .mem_be_o(mem_be_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
      .run_o(run_o), .eol_o(eol_o), .intr_o(intr_o));

   // memory with one-cycle read latency
   always @(posedge clk) begin
      if (mem_req_o) begin
         if (mem_we_o) begin
            for (int b = 0; b < 4; b++)
               if (mem_be_o[b]) mem[mem_addr_o][8*b +: 8] <= mem_wdata_o[8*b +: 8];
         end else begin
            mem_rdata_i <= mem[mem_addr_o];
         end
      end
   end

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp_v);
      tests++;
      if (got !== exp_v) begin
         fails++;
         $display("FAIL %s got %h expected %h", req, got, exp_v);
      end
   endtask

   // stream driver and per-clock write comparison
   initial begin
      forever begin
         @(negedge clk);
         if (sq.size() > 0) begin
            s_valid_i = 1'b1;
            s_data_i  = sq[0];
            s_eop_i   = seq_eop[0];
         end else begin
            s_valid_i = 1'b0;
            s_eop_i   = 1'b0;
         end
         #1;
         if (rst_n && mem_req_o && mem_we_o) begin
            logic [31:0] got_w, exp_w;
            got_w = '0;
            exp_w = '0;
            for (int b = 0; b < 4; b++) begin
               if (mem_be_o[b]) begin
                  got_w[8*b +: 8] = mem_wdata_o[8*b +: 8];
                  exp_w[8*b +: 8] = expm[mem_addr_o][8*b +: 8];
               end
            end
            chk("R3/R5/R6/R10 write matches model", got_w, exp_w);
         end
         if (s_valid_i && s_ready_o) begin
            void'(sq.pop_front());
            void'(seq_eop.pop_front());
         end
      end
   end

   task automatic put_word(input int w, input logic [31:0] v);
      mem[w]  = v;
      expm[w] = v;
   endtask

   task automatic set_desc(input int bytea, input logic [31:0] nx, input logic [31:0] st,
                           input logic [31:0] en, input logic [31:0] fl);
      put_word(bytea/4 + 0, nx);
      put_word(bytea/4 + 1, st);
      put_word(bytea/4 + 2, en);
      put_word(bytea/4 + 3, fl);
   endtask

   task automatic push_pkt(input logic [7:0] first, input int n, input bit eop_last);
      for (int i = 0; i < n; i++) begin
         logic e;
         e = eop_last && (i == n - 1);
         sq.push_back(first + 8'(i));
         seq_eop.push_back(e);
         mq.push_back(first + 8'(i));
         meq.push_back(e);
      end
   endtask

   // behavioural reference: walks the chain over the expected image
   task automatic run_model(input int first_w, input int ctx_w, output int used,
                            output bit eol_e, output bit intr_e);
      int d;
      int k;
      bit fin;
      d = first_w; k = 0; fin = 1'b0; eol_e = 1'b0; intr_e = 1'b0;
      while (!fin) begin
         logic [31:0] nx, st, en, fl;
         int pos;
         bit ec;
         nx = expm[d]; st = expm[d+1]; en = expm[d+2]; fl = expm[d+3];
         pos = int'(st); ec = 1'b0;
         while (pos != int'(en) && !ec && k < mq.size()) begin
            expm[pos/4][8*(pos%4) +: 8] = mq[k];
            ec = meq[k];
            k++;
            pos++;
         end
         if (pos != int'(en) && !ec) begin
            fin = 1'b1;
         end else begin
            expm[d+2] = 32'(pos);
            fl[2] = ec;
            expm[d+3] = fl;
            if (fl[1]) intr_e = 1'b1;
            if (fl[0]) begin
               expm[ctx_w] = 32'h1;
               eol_e = 1'b1;
               fin = 1'b1;
            end else begin
               d = int'(nx) / 4;
            end
         end
      end
      used = k;
      mq.delete();
      meq.delete();
   endtask

   task automatic kick(input int desc_byte, input int ctx_byte);
      @(negedge clk);
      desc_ptr_i = (AW-2)'(desc_byte / 4);
      ctx_ptr_i  = (AW-2)'(ctx_byte / 4);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk);
         if (!run_o) break;
      end
      repeat (4) @(negedge clk);
   endtask

   task automatic cmp_image(input string req);
      int bad;
      int first_bad;
      bad = 0;
      first_bad = 0;
      for (int w = 0; w < WORDS; w++)
         if (mem[w] !== expm[w]) begin
            if (bad == 0) first_bad = w;
            bad++;
         end
      chk(req, mem[first_bad], expm[first_bad]);
   endtask

   initial begin
      int used;
      bit eol_e, intr_e;
      for (int w = 0; w < WORDS; w++) put_word(w, (32'(w) * 32'h01010101) ^ 32'h5A5A5A5A);

      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 ready", {31'b0, s_ready_o}, 32'h0);
      chk("R1 run", {31'b0, run_o}, 32'h0);
      chk("R1 eol", {31'b0, eol_o}, 32'h0);
      chk("R1 intr", {31'b0, intr_o}, 32'h0);
      chk("R1 mem_req", {31'b0, mem_req_o}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // Chain 1: misaligned buffer closed by packet end, then filled buffer with end-of-list
      set_desc(12'h100, 32'h110, 32'h201, 32'h20A, 32'h0000F0F2);
      set_desc(12'h110, 32'h000, 32'h300, 32'h306, 32'h00000007);
      push_pkt(8'h11, 5, 1'b1);
      push_pkt(8'h21, 8, 1'b0);
      run_model(12'h100 / 4, 12'h180 / 4, used, eol_e, intr_e);
      chk("R2 ready low before start", {31'b0, s_ready_o}, 32'h0);
      kick(12'h100, 12'h180);
      chk("R4 bytes consumed", 32'(13 - sq.size()), 32'(used));
      chk("R8 bytes left unaccepted", 32'(sq.size()), 32'd2);
      chk("R8 eol set", {31'b0, eol_o}, {31'b0, eol_e});
      chk("R8 run low", {31'b0, run_o}, 32'h0);
      chk("R8 ready low at eol", {31'b0, s_ready_o}, 32'h0);
      chk("R7 intr raised", {31'b0, intr_o}, {31'b0, intr_e});
      chk("R5 end rewritten on packet end", mem[12'h108 / 4], 32'h206);
      chk("R6 flags pktend set", mem[12'h10C / 4], 32'h0000F0F6);
      chk("R5 end on full buffer", mem[12'h118 / 4], 32'h306);
      chk("R6 flags pktend cleared", mem[12'h11C / 4], 32'h00000003);
      chk("R8 context disabled", mem[12'h180 / 4], 32'h1);
      chk("R10 neighbour below buffer", {24'b0, mem[12'h200 / 4][7:0]},
          {24'b0, expm[12'h200 / 4][7:0]});
      chk("R10 neighbours after close", mem[12'h208 / 4], expm[12'h208 / 4]);
      chk("R3 first buffer word", mem[12'h204 / 4], expm[12'h204 / 4]);
      chk("R4 second buffer tail", mem[12'h304 / 4], expm[12'h304 / 4]);
      cmp_image("R3/R10 whole image chain 1");
      sq.delete();
      seq_eop.delete();

      // R7: clear
      @(negedge clk);
      intr_clr_i = 1'b1;
      @(negedge clk);
      intr_clr_i = 1'b0;
      chk("R7 intr cleared", {31'b0, intr_o}, 32'h0);

      // Chain 2: zero-length descriptor, then aligned buffer where fill and packet end coincide
      set_desc(12'h120, 32'h130, 32'h500, 32'h500, 32'h00000000);
      set_desc(12'h130, 32'h000, 32'h400, 32'h408, 32'h00000001);
      push_pkt(8'h80, 8, 1'b1);
      run_model(12'h120 / 4, 12'h190 / 4, used, eol_e, intr_e);
      kick(12'h120, 12'h190);
      chk("R9 all bytes consumed", 32'(sq.size()), 32'd0);
      chk("R9 zero-length end kept", mem[12'h128 / 4], 32'h500);
      chk("R9 zero-length flags", mem[12'h12C / 4], 32'h0);
      chk("R9 following buffer first word", mem[12'h400 / 4], 32'h83828180);
      chk("R4 coincident close end", mem[12'h138 / 4], 32'h408);
      chk("R6 coincident close flags", mem[12'h13C / 4], 32'h00000005);
      chk("R7 no intr without flag", {31'b0, intr_o}, 32'h0);
      chk("R8 context 2 disabled", mem[12'h190 / 4], 32'h1);
      chk("R8 eol after chain 2", {31'b0, eol_o}, {31'b0, eol_e});
      cmp_image("R3/R10 whole image chain 2");

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule